// File: doc/BRIEF.md
# On-Chip Data SRAM Router for Block-Move Accesses

This block sits between the CPU's external-data access port and two possible targets: a 1024-byte read/write data SRAM inside the block, and the off-chip memory bus. Each access carries a 16-bit address and a read or write strobe. The block decides which target serves the access. It drives the SRAM select, address and write enable, or it forwards the strobes to the external bus. It then returns the read data from the target it chose. The SRAM serves only data moves of this kind. Instructions are never fetched from it, and it is separate from the 256-byte scratchpad, which uses another address space.

A single enable bit, part of the power-control register, turns the on-chip window on. The bit is cleared by reset, so after reset every address from 0x0000 to 0xFFFF goes to the external bus. When the bit is set, the lowest 1024 addresses are served on chip and all other addresses still go outside. Reads return their data one clock after the strobe, whichever target served them.

Top module: `movx_route`

## Requirements
- R1: With the enable bit set, accesses to addresses 0x0000 to 0x03FF use the on-chip 1024 x 8 array: a write stores `acc_wdata` at `acc_addr[9:0]`, and a later read returns the stored byte.
- R2: Reset clears the enable bit. Until it is set, every access (0x0000 to 0xFFFF) goes to the external bus and `ram_cs` stays low.
- R3: With the enable bit set, accesses to addresses 0x0400 and above go to the external bus. `ext_addr` always equals `acc_addr`.
- R4: An on-chip access keeps `ext_rd` and `ext_wr` low. An external access keeps `ram_cs` and `ram_we` low.
- R5: Read data appears on `acc_rdata` in the cycle after the read strobe and comes from the target chosen for that read. External read data is sampled at the clock edge that ends the strobe cycle. `acc_rdata` holds until the next read.
- R6: A write to the enable bit (`cfg_we` high, value `cfg_en`) takes effect at the following clock edge. An access in the same cycle as the write is decoded with the old value.
- R7: If `acc_rd` and `acc_wr` are both high, the access is a write. No read strobe reaches either target, and `acc_rdata` keeps its previous value.
- R8: With neither strobe high, `ram_cs`, `ram_we`, `ext_rd` and `ext_wr` are all low.
- R9: Clearing the enable bit does not alter the array contents. After the bit is set again, reads return the bytes written before it was cleared.
- R10: After reset, `acc_rdata` is 0x00 until the first read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the on-chip enable bit |
| cfg_en | input | 1 | New value of the on-chip enable bit |
| acc_addr | input | 16 | Access address |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid the cycle after a read |
| ram_cs | output | 1 | On-chip SRAM select |
| ram_we | output | 1 | On-chip SRAM write enable |
| ram_addr | output | 10 | On-chip SRAM address |
| ext_addr | output | 16 | External bus address |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data |

## Verification
Two events can fall in the same cycle: a write to the enable bit and an access whose routing depends on that bit. The bench provokes this by toggling the bit in both directions while reads and writes target the 0x0000 to 0x03FF window. It checks that the access in that cycle follows the old setting and the next access follows the new one. The bench model keeps its own copy of the bit and applies the update only after it has decoded the access in that cycle. Every strobe and the returned data are compared against the model on every clock.

// File: rtl/movx_pkg.sv
package movx_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;

  // Window test: the access goes on chip when enabled and below depth.
  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic en,
                                     input int unsigned depth);
    logic [31:0] wide;
    wide = {{(32-ADDR_W){1'b0}}, a};
    return en && (wide < depth);
  endfunction

  // A write strobe wins over a concurrent read strobe.
  function automatic logic eff_read(input logic rd, input logic wr);
    return rd && !wr;
  endfunction
endpackage

// File: rtl/movx_cfg_bit.sv
module movx_cfg_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/movx_decode.sv
module movx_decode
  import movx_pkg::*;
#(
  parameter int unsigned DEPTH = 1024
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              en,
  output logic              hit,
  output logic              ram_cs,
  output logic              ram_we,
  output logic              ram_rd,
  output logic              ext_rd,
  output logic              ext_wr
);
  logic rd_eff;

  always_comb begin
    hit    = in_window(addr, en, DEPTH);
    rd_eff = eff_read(rd, wr);
    ram_cs = hit && (rd || wr);
    ram_we = hit && wr;
    ram_rd = hit && rd_eff;
    ext_rd = !hit && rd_eff;
    ext_wr = !hit && wr;
  end
endmodule

// File: rtl/movx_sram.sv
module movx_sram #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cs && we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata <= '0;
    else if (cs && !we)  rdata <= mem[addr];
  end
endmodule

// File: rtl/movx_rdmux.sv
module movx_rdmux #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_ram,
  input  logic          rd_ext,
  input  logic [DW-1:0] ram_q,
  input  logic [DW-1:0] ext_d,
  output logic [DW-1:0] rdata
);
  logic          sel_ram_q;
  logic [DW-1:0] ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_ram_q <= 1'b0;
      ext_q     <= '0;
    end else begin
      if (rd_ram || rd_ext) sel_ram_q <= rd_ram;
      if (rd_ext)           ext_q     <= ext_d;
    end
  end

  assign rdata = sel_ram_q ? ram_q : ext_q;
endmodule

// File: rtl/movx_route.sv
module movx_route
  import movx_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned RAW  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [RAW-1:0]    ram_addr,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic [DATA_W-1:0] ext_rdata
);
  // Named internal events for the checker.
  logic              en_q;
  logic              win_hit;
  logic              ram_rd_ev;
  logic [DATA_W-1:0] ram_q;

  movx_cfg_bit u_cfg (
    .clk (clk), .rst_n (rst_n), .we (cfg_we), .d (cfg_en), .q (en_q)
  );

  movx_decode #(.DEPTH(DEPTH)) u_dec (
    .addr   (acc_addr),
    .rd     (acc_rd),
    .wr     (acc_wr),
    .en     (en_q),
    .hit    (win_hit),
    .ram_cs (ram_cs),
    .ram_we (ram_we),
    .ram_rd (ram_rd_ev),
    .ext_rd (ext_rd),
    .ext_wr (ext_wr)
  );

  assign ram_addr  = acc_addr[RAW-1:0];
  assign ext_addr  = acc_addr;
  assign ext_wdata = acc_wdata;

  movx_sram #(.DEPTH(DEPTH), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .cs    (ram_cs),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (acc_wdata),
    .rdata (ram_q)
  );

  movx_rdmux #(.DW(DATA_W)) u_mux (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_ram (ram_rd_ev),
    .rd_ext (ext_rd),
    .ram_q  (ram_q),
    .ext_d  (ext_rdata),
    .rdata  (acc_rdata)
  );
endmodule

// File: rtl/movx_route_chk.sv
module movx_route_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        cfg_en,
  input logic [15:0] acc_addr,
  input logic        acc_rd,
  input logic        acc_wr,
  input logic [7:0]  acc_rdata,
  input logic        ram_cs,
  input logic        ram_we,
  input logic        ext_rd,
  input logic        ext_wr,
  input logic [7:0]  ext_rdata,
  input logic        en_q
);
  p_onchip_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> (!ext_rd && !ext_wr));

  p_ext_no_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd || ext_wr) |-> (!ram_cs && !ram_we));

  p_off_all_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !ram_cs);

  p_high_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd || acc_wr) && (acc_addr[15:10] != 6'd0)) |-> !ram_cs);

  p_ext_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd |=> (acc_rdata == $past(ext_rdata)));

  p_enable_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (en_q == $past(cfg_en)));

  p_wr_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_wr) |-> !ext_rd);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_wr) |=> $stable(acc_rdata));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_rd && !acc_wr) |-> (!ram_cs && !ram_we && !ext_rd && !ext_wr));
endmodule

bind movx_route movx_route_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_en    (cfg_en),
  .acc_addr  (acc_addr),
  .acc_rd    (acc_rd),
  .acc_wr    (acc_wr),
  .acc_rdata (acc_rdata),
  .ram_cs    (ram_cs),
  .ram_we    (ram_we),
  .ext_rd    (ext_rd),
  .ext_wr    (ext_wr),
  .ext_rdata (ext_rdata),
  .en_q      (en_q)
);

// File: tb/sim_movx_route.sv
module sim_movx_route;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_en = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        acc_rd = 1'b0, acc_wr = 1'b0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  acc_rdata;
  logic        ram_cs, ram_we, ext_rd, ext_wr;
  logic [9:0]  ram_addr;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata, ext_rdata;

  int total = 0, bad = 0;
  bit done = 0;

  // Reference model state.
  byte unsigned m_mem [int];
  bit           m_en = 0;
  int           m_rdata = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] ext_src(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign ext_rdata = ext_src(ext_addr);

  movx_route u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr),
    .ext_addr(ext_addr), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // One clock of stimulus, compared against the model before the edge.
  task automatic step(input string rq, input bit rd, input bit wr,
                      input logic [15:0] a, input logic [7:0] d,
                      input bit cw = 0, input bit cd = 0);
    bit hit, r_eff;
    @(negedge clk);
    acc_rd = rd; acc_wr = wr; acc_addr = a; acc_wdata = d;
    cfg_we = cw; cfg_en = cd;
    #1;
    hit   = m_en && (a < 16'h0400);
    r_eff = rd && !wr;
    chk(rq, "ram_cs", ram_cs, hit && (rd || wr));
    chk(rq, "ram_we", ram_we, hit && wr);
    chk(rq, "ext_rd", ext_rd, !hit && r_eff);
    chk(rq, "ext_wr", ext_wr, !hit && wr);
    chk(rq, "ext_addr", ext_addr, a);
    if (hit) chk(rq, "ram_addr", ram_addr, a[9:0]);
    if (!hit && wr) chk(rq, "ext_wdata", ext_wdata, d);
    chk(rq, "acc_rdata", acc_rdata, m_rdata);
    @(posedge clk);
    if (wr) begin
      if (hit) m_mem[int'(a)] = d;
    end else if (rd) begin
      if (hit) m_rdata = m_mem.exists(int'(a)) ? m_mem[int'(a)] : 0;
      else     m_rdata = ext_src(a);
    end
    if (cw) m_en = cd;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R10: reset state of read data and strobes
    #1 chk("R10", "acc_rdata after reset", acc_rdata, 0);
    step("R8", 0, 0, 16'h0000, 8'h00);
    // R2: disabled, low addresses go outside
    step("R2", 0, 1, 16'h0010, 8'hA1);
    step("R2", 1, 0, 16'h0010, 8'h00);
    step("R2", 1, 0, 16'hFFFF, 8'h00);
    step("R5", 0, 0, 16'h0000, 8'h00);
    // R6: enable written with a same-cycle access (still external)
    step("R6", 0, 1, 16'h0020, 8'h11, 1, 1);
    step("R6", 1, 0, 16'h0020, 8'h00);
    // R1: on-chip writes and reads across the window, incl. edges
    step("R1", 0, 1, 16'h0000, 8'h3C);
    step("R1", 0, 1, 16'h03FF, 8'hC3);
    step("R1", 0, 1, 16'h0155, 8'h77);
    step("R1", 1, 0, 16'h0000, 8'h00);
    step("R1", 1, 0, 16'h03FF, 8'h00);
    step("R5", 1, 0, 16'h0155, 8'h00);
    step("R5", 0, 0, 16'h0000, 8'h00);
    // R3: above window goes outside even when enabled
    step("R3", 0, 1, 16'h0400, 8'h99);
    step("R3", 1, 0, 16'h0400, 8'h00);
    step("R3", 1, 0, 16'hFFFF, 8'h00);
    step("R4", 1, 0, 16'h03FF, 8'h00);
    // R7: both strobes treated as write, read data held
    step("R7", 1, 1, 16'h0155, 8'h5E);
    step("R7", 1, 1, 16'h8000, 8'h5F);
    step("R7", 1, 0, 16'h0155, 8'h00);
    // R6: disable in same cycle as an on-chip read (still on chip)
    step("R6", 1, 0, 16'h0000, 8'h00, 1, 0);
    step("R6", 1, 0, 16'h0000, 8'h00);
    step("R9", 0, 1, 16'h03FF, 8'hEE);
    // R9: re-enable, earlier contents still there
    step("R9", 0, 0, 16'h0000, 8'h00, 1, 1);
    step("R9", 1, 0, 16'h03FF, 8'h00);
    step("R9", 1, 0, 16'h0155, 8'h00);
    step("R8", 0, 0, 16'h0155, 8'h00);
    // Mixed pattern with pseudo-random addresses and enable toggles
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a = lf[0] ? {6'd0, lf[10:1]} : lf;
      if (lf[3:1] == 3'd0)
        step("R6", lf[4], 0, a, lf[15:8], 1, lf[5] | lf[6]);
      else if (lf[5:4] == 2'd0 || !m_mem.exists(int'(a)) && a < 16'h0400 && lf[6])
        step("R1", 0, 1, a, lf[15:8]);
      else if (lf[7])
        step("R5", (a >= 16'h0400 || m_mem.exists(int'(a)) || !m_en), 0, a, 8'h00);
      else
        step("R8", 0, 0, a, 8'h00);
    end
    step("R5", 0, 0, 16'h0000, 8'h00);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule